// File: doc/BRIEF.md
# Pipelined Thermometer-to-Binary Flash Encoder

This block is the digital back end of an n-bit flash converter. Each clock it can accept one thermometer word of 2^n−1 bits from a comparator bank and, a fixed number of cycles later, present the matching n-bit binary code. The word first passes an input register. An edge detector then turns it into a one-hot word of 2^n lines. Line i is set when comparator i−1 is high and comparator i is low. The bit below the word counts as high and the bit above it counts as low.

Each binary output bit is built as a balanced tree of two-input ORs. Bit k collects the one-hot lines whose index has bit k set. When the pipelining option is on, every OR level of every tree is registered, so one sample completes per clock and the logic depth between flops is a single OR gate. When the option is off, the trees are purely combinational. A valid flag travels through the same number of stages as the data. A synchronous reset empties every stage.

Top module: `therm_flash_encoder`

## Requirements
- R1: With a well-formed thermometer input whose ones occupy bits 0 to k−1 (and no others), the output code equals k, for every k from 0 to 2^NBITS−1.
- R2: An all-zero input gives code 0, and an all-one input gives the full-scale code 2^NBITS−1.
- R3: With PIPE=1 the result of an input sampled at a rising edge appears NBITS rising edges later (one input register plus NBITS−1 tree levels); with PIPE=0 it appears after one rising edge.
- R4: valid_o is high in exactly those cycles that follow, at the R3 latency, a cycle in which valid_i was high; back-to-back inputs yield back-to-back outputs, one per clock.
- R5: While rst is high at a rising edge, that edge clears valid_o and code_o to 0, and no sample accepted before the reset emerges afterwards.
- R6: For a malformed input, one-hot line i is set when bit i−1 is 1 and bit i is 0 (bit −1 read as 1, bit 2^NBITS−1 read as 0), and the code is the bitwise OR of the indices of all set lines.
- R7: The block is built with NBITS=8 and PIPE=0 as well, takes a 255-bit input, and produces every code from 0 to 255 with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers use its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Marks therm_i as a sample in this cycle |
| therm_i | input | 2^NBITS−1 | Comparator outputs; bit j is comparator j, counted from the lowest threshold |
| valid_o | output | 1 | Marks code_o as a result |
| code_o | output | NBITS | Binary sample code |

## Verification
Each result is due a fixed number of rising edges after its input: NBITS edges for the pipelined 6-bit instance and one edge for the combinational 8-bit instance. The reset clear is due at the first edge with rst high. The bench drives inputs and samples outputs on falling edges. A falling edge that follows a drive by exactly the latency count of rising edges is where the result of that drive is read. In a streamed run, each falling edge checks the sample driven that many edges earlier, so throughput and latency are both tested. Valid gaps and a mid-stream reset show that valid_o appears only at that offset.

// File: rtl/therm_enc_pkg.sv
package therm_enc_pkg;

   // Width of the thermometer word for a given resolution.
   function automatic int unsigned therm_width(input int unsigned nbits);
      return (1 << nbits) - 1;
   endfunction

   // Index of the m-th one-hot line whose index has bit k set:
   // a 1 is inserted at position k into the value m.
   function automatic int unsigned spread_index(input int unsigned m, input int unsigned k);
      int unsigned low_mask;
      low_mask = (1 << k) - 1;
      return ((m >> k) << (k + 1)) | (1 << k) | (m & low_mask);
   endfunction

   // Number of pipeline stages after the input register.
   function automatic int unsigned tree_stages(input int unsigned nbits, input bit pipe);
      return pipe ? (nbits - 1) : 0;
   endfunction

endpackage

// File: rtl/therm_edge_gen.sv
module therm_edge_gen #(
   parameter int unsigned NBITS = 6
) (
   input  logic [(2**NBITS)-2:0] therm,
   output logic [(2**NBITS)-1:0] lines
);
   localparam int unsigned NLINES = 2**NBITS;

   // Extended word: a constant high below, a constant low above.
   logic [NLINES:0] ext;
   assign ext = {1'b0, therm, 1'b1};

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      assign lines[i] = ext[i] & ~ext[i+1];
   end
endmodule

// File: rtl/or_tree.sv
module or_tree #(
   parameter int unsigned LOG2N = 5,
   parameter bit          PIPE  = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [(2**LOG2N)-1:0] leaves,
   output logic                root
);
   for (genvar lv = 0; lv <= LOG2N; lv++) begin : g_lvl
      localparam int unsigned WL = 2**(LOG2N - lv);
      logic [WL-1:0] val;

      if (lv == 0) begin : g_leaf
         assign val = leaves;
      end else begin : g_node
         logic [WL-1:0] nxt;
         always_comb begin
            for (int j = 0; j < WL; j++) begin
               nxt[j] = g_lvl[lv-1].val[2*j] | g_lvl[lv-1].val[2*j+1];
            end
         end

         if (PIPE) begin : g_reg
            always_ff @(posedge clk) begin
               if (rst) val <= '0;
               else     val <= nxt;
            end
         end else begin : g_comb
            assign val = nxt;
         end
      end
   end

   assign root = g_lvl[LOG2N].val[0];
endmodule

// File: rtl/valid_delay.sv
module valid_delay #(
   parameter int unsigned DEPTH = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   if (DEPTH == 0) begin : g_pass
      assign dout = din;
   end else begin : g_shift
      logic [DEPTH-1:0] sr;
      always_ff @(posedge clk) begin
         if (rst) begin
            sr <= '0;
         end else begin
            sr[0] <= din;
            for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
         end
      end
      assign dout = sr[DEPTH-1];
   end
endmodule

// File: rtl/therm_flash_encoder.sv
module therm_flash_encoder
   import therm_enc_pkg::*;
#(
   parameter int unsigned NBITS = 6,
   parameter bit          PIPE  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  valid_i,
   input  logic [(2**NBITS)-2:0] therm_i,
   output logic                  valid_o,
   output logic [NBITS-1:0]      code_o
);
   localparam int unsigned TW     = therm_width(NBITS);
   localparam int unsigned NLINES = 2**NBITS;
   localparam int unsigned LEVELS = NBITS - 1;
   localparam int unsigned HALF   = 2**LEVELS;
   localparam int unsigned STAGES = tree_stages(NBITS, PIPE);

   // Elaboration-time parameter checks.
   if (NBITS < 2 || NBITS > 10) begin : g_bad_nbits
      $error("therm_flash_encoder: NBITS must lie in 2..10");
   end
   if (TW != NLINES - 1) begin : g_bad_width
      $error("therm_flash_encoder: thermometer width mismatch");
   end

   // Input register.
   logic [TW-1:0] therm_q;
   logic          vld_q;
   always_ff @(posedge clk) begin
      if (rst) begin
         therm_q <= '0;
         vld_q   <= 1'b0;
      end else begin
         therm_q <= therm_i;
         vld_q   <= valid_i;
      end
   end

   // Edge detection: thermometer to one-hot.
   logic [NLINES-1:0] onehot_w;
   therm_edge_gen #(.NBITS(NBITS)) u_edge (
      .therm (therm_q),
      .lines (onehot_w)
   );

   // One balanced OR tree per output bit.
   for (genvar k = 0; k < NBITS; k++) begin : g_bit
      logic [HALF-1:0] leaves;
      for (genvar m = 0; m < HALF; m++) begin : g_leaf
         assign leaves[m] = onehot_w[spread_index(m, k)];
      end
      or_tree #(.LOG2N(LEVELS), .PIPE(PIPE)) u_tree (
         .clk    (clk),
         .rst    (rst),
         .leaves (leaves),
         .root   (code_o[k])
      );
   end

   // Valid flag follows the data through the tree stages.
   valid_delay #(.DEPTH(STAGES)) u_vdly (
      .clk  (clk),
      .rst  (rst),
      .din  (vld_q),
      .dout (valid_o)
   );
endmodule

// File: rtl/therm_flash_encoder_chk.sv
module therm_flash_encoder_chk #(
   parameter int unsigned NBITS = 6,
   parameter bit          PIPE  = 1'b1
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  valid_i,
   input logic [(2**NBITS)-2:0] therm_i,
   input logic                  valid_o,
   input logic [NBITS-1:0]      code_o,
   input logic [(2**NBITS)-2:0] therm_q,
   input logic [(2**NBITS)-1:0] onehot
);
   localparam int unsigned LAT = 1 + (PIPE ? (NBITS - 1) : 0);

   logic                  in_ok;
   logic [NBITS-1:0]      in_cnt;
   logic                  q_ok;
   assign in_ok  = ((therm_i & (therm_i + 1'b1)) == '0);
   assign in_cnt = NBITS'($countones(therm_i));
   assign q_ok   = ((therm_q & (therm_q + 1'b1)) == '0);

   // Reference model of the latency path, built from the requirements.
   logic [LAT-1:0]   vsr;
   logic [LAT-1:0]   oksr;
   logic [NBITS-1:0] esr [LAT];
   always_ff @(posedge clk) begin
      if (rst) begin
         vsr  <= '0;
         oksr <= '0;
         for (int i = 0; i < LAT; i++) esr[i] <= '0;
      end else begin
         vsr[0]  <= valid_i;
         oksr[0] <= in_ok;
         esr[0]  <= in_cnt;
         for (int i = 1; i < LAT; i++) begin
            vsr[i]  <= vsr[i-1];
            oksr[i] <= oksr[i-1];
            esr[i]  <= esr[i-1];
         end
      end
   end

   AST_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
      q_ok |-> ($countones(onehot) == 1));                          // R1
   AST_EMPTY_LINE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (therm_q == '0) |-> (onehot[0] && $countones(onehot) == 1));  // R2
   AST_CODE_COUNT: assert property (@(posedge clk) disable iff (rst)
      (valid_o && oksr[LAT-1]) |-> (code_o == esr[LAT-1]));         // R1
   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
      valid_o == vsr[LAT-1]);                                       // R3
   AST_RESET_CLEAR: assert property (@(posedge clk)
      $past(rst) |-> (!valid_o && code_o == '0));                   // R5
endmodule

bind therm_flash_encoder therm_flash_encoder_chk #(.NBITS(NBITS), .PIPE(PIPE)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .valid_i (valid_i),
   .therm_i (therm_i),
   .valid_o (valid_o),
   .code_o  (code_o),
   .therm_q (therm_q),
   .onehot  (onehot_w)
);

// File: tb/sim_therm_flash_encoder.sv
`timescale 1ns/1ps
module sim_therm_flash_encoder;
   localparam int LAT0 = 6;   // R3: NBITS=6, PIPE=1
   localparam int LAT1 = 1;   // R3/R7: PIPE=0

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic        valid0 = 1'b0;
   logic [62:0] therm0 = '0;
   logic        vo0;
   logic [5:0]  code0;

   logic         valid1 = 1'b0;
   logic [254:0] therm1 = '0;
   logic         vo1;
   logic [7:0]   code1;

   therm_flash_encoder #(.NBITS(6), .PIPE(1'b1)) u0 (
      .clk(clk), .rst(rst), .valid_i(valid0), .therm_i(therm0),
      .valid_o(vo0), .code_o(code0));

   therm_flash_encoder #(.NBITS(8), .PIPE(1'b0)) u1 (
      .clk(clk), .rst(rst), .valid_i(valid1), .therm_i(therm1),
      .valid_o(vo1), .code_o(code1));

   int n_chk  = 0;
   int n_fail = 0;

   // Stimulus {thermometer, expected code} for the 6-bit instance.
   localparam logic [68:0] TBL [12] = '{
      {63'h0,                  6'd0},
      {63'h1,                  6'd1},
      {63'h7FFF_FFFF,          6'd31},
      {63'hFFFF_FFFF,          6'd32},
      {63'h7FFF_FFFF_FFFF_FFFF, 6'd63},
      {63'h27,                 6'd7},
      {63'h2,                  6'd2},
      {63'h4000_0000_0000_0000, 6'd63},
      {63'h5,                  6'd3},
      {63'h15,                 6'd7},
      {63'h10F,                6'd13},
      {63'hA,                  6'd6}
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [254:0] therm_of(input int k);
      logic [254:0] t;
      t = '0;
      for (int b = 0; b < k; b++) t[b] = 1'b1;
      return t;
   endfunction

   // Expected code of any word, from the edge rule of R6.
   function automatic int exp_code(input logic [254:0] t, input int nb);
      int nl;
      logic [256:0] ext;
      int c;
      nl = 1 << nb;
      ext = '0;
      ext[0] = 1'b1;
      for (int j = 1; j < nl; j++) ext[j] = t[j-1];
      c = 0;
      for (int i = 0; i < nl; i++) if (ext[i] && !ext[i+1]) c = c | i;
      return c;
   endfunction

   initial begin
      #(100000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // Reset state (R5)
      repeat (3) @(negedge clk);
      chk("R5", "valid_o in reset", int'(vo0), 0);
      chk("R5", "code_o in reset", int'(code0), 0);
      rst = 1'b0;

      // Table walk: single samples, legal and malformed (R2, R6)
      for (int e = 0; e < 12; e++) begin
         @(negedge clk);
         therm0 = TBL[e][68:6];
         valid0 = 1'b1;
         @(negedge clk);
         valid0 = 1'b0;
         repeat (LAT0 - 1) @(negedge clk);
         chk("R3", "valid_o at latency", int'(vo0), 1);
         chk("R6", "table code", int'(code0), int'(TBL[e][5:0]));
         chk("R6", "model agrees", exp_code({192'b0, TBL[e][68:6]}, 6), int'(TBL[e][5:0]));
         @(negedge clk);
         chk("R4", "valid_o single pulse", int'(vo0), 0);
      end

      // Back-to-back sweep of every legal word (R1, R2, R4)
      for (int j = 0; j < 64 + LAT0; j++) begin
         @(negedge clk);
         if (j >= LAT0) begin
            chk("R4", "stream valid", int'(vo0), 1);
            if (j - LAT0 == 0 || j - LAT0 == 63)
               chk("R2", "end-scale code", int'(code0), j - LAT0);
            else
               chk("R1", "stream code", int'(code0), j - LAT0);
         end
         if (j < 64) begin
            therm0 = therm_of(j)[62:0];
            valid0 = 1'b1;
         end else begin
            valid0 = 1'b0;
         end
      end

      // Valid gaps: every third sample is idle (R4)
      for (int j = 0; j < 30 + LAT0; j++) begin
         @(negedge clk);
         if (j >= LAT0) begin
            chk("R4", "gapped valid", int'(vo0), ((j - LAT0) % 3 != 1) ? 1 : 0);
            if ((j - LAT0) % 3 != 1)
               chk("R4", "gapped code", int'(code0), (j - LAT0) * 2);
         end
         if (j < 30) begin
            therm0 = therm_of(j * 2)[62:0];
            valid0 = (j % 3 != 1);
         end else begin
            valid0 = 1'b0;
         end
      end

      // Reset during a stream (R5)
      for (int j = 0; j < 3; j++) begin
         @(negedge clk);
         therm0 = therm_of(40 + j)[62:0];
         valid0 = 1'b1;
      end
      @(negedge clk);
      rst = 1'b1;
      valid0 = 1'b0;
      @(negedge clk);
      chk("R5", "valid_o after reset edge", int'(vo0), 0);
      chk("R5", "code_o after reset edge", int'(code0), 0);
      rst = 1'b0;
      for (int j = 0; j < LAT0 + 2; j++) begin
         @(negedge clk);
         chk("R5", "no leftover sample", int'(vo0), 0);
      end

      // 8-bit combinational-tree instance: every code, one cycle (R7)
      for (int j = 0; j < 256 + LAT1; j++) begin
         @(negedge clk);
         if (j >= LAT1) begin
            chk("R7", "8-bit valid", int'(vo1), 1);
            chk("R7", "8-bit code", int'(code1), j - LAT1);
         end
         if (j < 256) begin
            therm1 = therm_of(j);
            valid1 = 1'b1;
         end else begin
            valid1 = 1'b0;
         end
      end

      // 8-bit malformed word: bits 0 and 200 set (R6)
      @(negedge clk);
      therm1 = '0;
      therm1[0] = 1'b1;
      therm1[200] = 1'b1;
      valid1 = 1'b1;
      @(negedge clk);
      valid1 = 1'b0;
      chk("R6", "8-bit malformed code", int'(code1), 201);
      chk("R6", "8-bit model agrees", exp_code(therm1, 8), 201);

      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule